// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control register file of an audio codec. A host reaches it through four byte-wide direct ports selected by a two-bit address: an index port, an indirect data port, a status port and a programmed-I/O data port. The index port selects one register in a bank of 32 control bytes, and the data port reads or writes that register. In the compatible mode only the lower 16 registers are reachable. Setting the extended-mode bit opens the whole bank.

Each register has its own write rule. The sample-format register only changes while the mode-change enable in the index is set, or in part while the partial enable in the alternate status register is set. The read-only and reserved locations keep their value. Only the extended-mode bit of the mode register is writable. An end-of-block event from the data path raises an interrupt. The host clears it either by writing the status port or by clearing the playback-interrupt flag. After the mode-change enable is switched on with calibration requested, a busy flag appears on a configurable number of reads of the error/init register.

The decoded format, interface configuration, extended-mode bit and 16-bit playback block count leave the block as outputs for the data path.

Top module: `codec_regfile`

## Requirements
- R1: After reset the index reads 0x40. Registers 2, 3, 4, 5, 18 and 19 read 0x88. Registers 6 and 7 read 0x80. Register 9 reads 0x08, register 12 reads 0x8A, and registers 25 and 26 read 0xA0. All other registers and the interrupt read 0.
- R2: A write to port 0 stores the byte with bit 7 cleared, and a read of port 0 returns the stored index, so bit 7 always reads 0. Index bit 6 is the mode-change enable (MCE).
- R3: The register selected through port 1 is index[3:0] when bit 6 of register 12 is 0, and index[4:0] when it is 1.
- R4: A write to register 8 replaces the whole byte when MCE is 1. When MCE is 0 and bit 4 of register 24 is 1, it replaces only bits 7:4. In every other case the write is dropped.
- R5: Writes to register 9 store the data with bit 5 forced to 0. Writes to register 11 and to the reserved registers 22, 27 and 29 leave them unchanged.
- R6: A write to register 12 changes only bit 6; the other bits stay at 0x8A's values.
- R7: When MCE goes from 0 to 1 through a port-0 write while register 9 bits 4:3 are nonzero, the next CAL_READS reads of register 11 return bit 5 set, each such read using up one. A later rising edge reloads the count.
- R8: Any write to port 2 clears INT, clears bits 6:4 of register 24 and drops irq_o.
- R9: A pulse on irq_set_i sets INT (irq_o) and bit 4 of register 24. If it coincides with a clearing write, the set wins.
- R10: A write to register 24 with data bit 4 at 0, while stored bit 4 is 1, clears INT. The register takes the written byte.
- R11: Writes to port 3 change nothing, and reads of port 3 return 0. A read of port 2 returns {7'b0, INT} and has no side effect.
- R12: Read data appears on rdata_o in the cycle after the access and holds until the next read. fmt_o, iface_o, mode2_o and blk_count_o ({reg14, reg15}) follow the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Direct port: 0 index, 1 data, 2 status, 3 PIO data |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Registered read byte |
| irq_set_i | input | 1 | End-of-block event from the data path |
| irq_o | output | 1 | Interrupt line (INT) |
| fmt_o | output | 8 | Register 8, sample format |
| iface_o | output | 8 | Register 9, interface configuration |
| mode2_o | output | 1 | Extended-mode bit (register 12 bit 6) |
| blk_count_o | output | 16 | Playback block count {reg14, reg15} |

## Verification
The bench builds the block with CAL_READS = 3. With that value a single rising edge of the mode-change enable produces three busy reads of register 11 before the flag drops. A reload can be triggered while reads remain, which the default count of 1 cannot show. Random traffic flips the extended-mode bit, so both index masks and the reserved slots above 15 are exercised against the bench's own register model.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned AW       = $clog2(NUM_REGS);

  localparam logic [1:0] PORT_IDX  = 2'd0;
  localparam logic [1:0] PORT_DAT  = 2'd1;
  localparam logic [1:0] PORT_STAT = 2'd2;
  localparam logic [1:0] PORT_PIO  = 2'd3;

  localparam logic [AW-1:0] R_FMT     = AW'(8);
  localparam logic [AW-1:0] R_IFACE   = AW'(9);
  localparam logic [AW-1:0] R_ERRINIT = AW'(11);
  localparam logic [AW-1:0] R_MODE    = AW'(12);
  localparam logic [AW-1:0] R_CNT_HI  = AW'(14);
  localparam logic [AW-1:0] R_CNT_LO  = AW'(15);
  localparam logic [AW-1:0] R_RSV_A   = AW'(22);
  localparam logic [AW-1:0] R_ALTSTAT = AW'(24);
  localparam logic [AW-1:0] R_RSV_B   = AW'(27);
  localparam logic [AW-1:0] R_RSV_C   = AW'(29);

  localparam int unsigned MCE_BIT   = 6;
  localparam int unsigned MODE2_BIT = 6;
  localparam int unsigned PINT_BIT  = 4;
  localparam int unsigned BUSY_BIT  = 5;

  function automatic logic [7:0] reset_val(input int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: reset_val = 8'h88;
      6, 7:               reset_val = 8'h80;
      9:                  reset_val = 8'h08;
      12:                 reset_val = 8'h8A;
      25, 26:             reset_val = 8'hA0;
      default:            reset_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_index.sv
module codec_index
  import codec_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          mode2_i,
  input  logic [1:0]    cal_req_i,
  output logic [7:0]    idx_o,
  output logic [AW-1:0] iaddr_o,
  output logic          cal_arm_o
);
  logic [7:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= 8'h40;
    else if (wr_i) idx_q <= {1'b0, wdata_i[6:0]};
  end

  assign idx_o     = idx_q;
  assign iaddr_o   = mode2_i ? idx_q[AW-1:0] : {1'b0, idx_q[AW-2:0]};
  assign cal_arm_o = wr_i && !idx_q[MCE_BIT] && wdata_i[MCE_BIT] && (cal_req_i != 2'b00);
endmodule

// File: rtl/codec_calib.sv
module codec_calib #(
  parameter int unsigned CAL_READS = 1,
  localparam int unsigned CW = $clog2(CAL_READS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic take_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (arm_i)               cnt_q <= CW'(CAL_READS);
    else if (take_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/codec_bank.sv
module codec_bank
  import codec_regs_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [7:0]               wdata_i,
  input  logic                     mce_i,
  input  logic                     stat_clr_i,
  input  logic                     irq_set_i,
  output logic [NUM_REGS-1:0][7:0] regs_o,
  output logic                     int_o
);
  logic [NUM_REGS-1:0][7:0] regs_q, regs_d;
  logic                     int_q, int_d;

  always_comb begin
    regs_d = regs_q;
    int_d  = int_q;
    if (wr_i) begin
      case (waddr_i)
        R_FMT: begin
          if (mce_i) regs_d[R_FMT] = wdata_i;
          else if (regs_q[R_ALTSTAT][PINT_BIT])
            regs_d[R_FMT] = {wdata_i[7:4], regs_q[R_FMT][3:0]};
        end
        R_IFACE: regs_d[R_IFACE] = wdata_i & 8'hDF;
        R_ERRINIT, R_RSV_A, R_RSV_B, R_RSV_C: ;
        R_MODE: regs_d[R_MODE][MODE2_BIT] = wdata_i[MODE2_BIT];
        R_ALTSTAT: begin
          if (regs_q[R_ALTSTAT][PINT_BIT] && !wdata_i[PINT_BIT]) int_d = 1'b0;
          regs_d[R_ALTSTAT] = wdata_i;
        end
        default: regs_d[waddr_i] = wdata_i;
      endcase
    end
    if (stat_clr_i) begin
      int_d = 1'b0;
      regs_d[R_ALTSTAT][6:4] = 3'b000;
    end
    // end-of-block event takes priority over any clear
    if (irq_set_i) begin
      int_d = 1'b1;
      regs_d[R_ALTSTAT][PINT_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reset_val(i);
      int_q <= 1'b0;
    end else begin
      regs_q <= regs_d;
      int_q  <= int_d;
    end
  end

  assign regs_o = regs_q;
  assign int_o  = int_q;
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
#(
  parameter int unsigned CAL_READS = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        irq_set_i,
  output logic        irq_o,
  output logic [7:0]  fmt_o,
  output logic [7:0]  iface_o,
  output logic        mode2_o,
  output logic [15:0] blk_count_o
);
  logic                     wr_idx, wr_dat, wr_stat, rd;
  logic [7:0]               idx;
  logic [AW-1:0]            iaddr;
  logic                     cal_arm, cal_take, busy, int_q;
  logic [NUM_REGS-1:0][7:0] bank_q;
  logic [7:0]               rd_mux, rdata_q;

  assign wr_idx  = cs_i && we_i && (addr_i == PORT_IDX);
  assign wr_dat  = cs_i && we_i && (addr_i == PORT_DAT);
  assign wr_stat = cs_i && we_i && (addr_i == PORT_STAT);
  assign rd      = cs_i && !we_i;

  codec_index u_index (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_idx),
    .wdata_i   (wdata_i),
    .mode2_i   (bank_q[R_MODE][MODE2_BIT]),
    .cal_req_i (bank_q[R_IFACE][4:3]),
    .idx_o     (idx),
    .iaddr_o   (iaddr),
    .cal_arm_o (cal_arm)
  );

  assign cal_take = rd && (addr_i == PORT_DAT) && (iaddr == R_ERRINIT);

  codec_calib #(.CAL_READS(CAL_READS)) u_calib (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (cal_arm),
    .take_i (cal_take),
    .busy_o (busy)
  );

  codec_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_dat),
    .waddr_i    (iaddr),
    .wdata_i    (wdata_i),
    .mce_i      (idx[MCE_BIT]),
    .stat_clr_i (wr_stat),
    .irq_set_i  (irq_set_i),
    .regs_o     (bank_q),
    .int_o      (int_q)
  );

  always_comb begin
    case (addr_i)
      PORT_IDX:  rd_mux = idx;
      PORT_DAT: begin
        rd_mux = bank_q[iaddr];
        if (iaddr == R_ERRINIT && busy) rd_mux[BUSY_BIT] = 1'b1;
      end
      PORT_STAT: rd_mux = {7'b0, int_q};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= 8'h00;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign irq_o       = int_q;
  assign fmt_o       = bank_q[R_FMT];
  assign iface_o     = bank_q[R_IFACE];
  assign mode2_o     = bank_q[R_MODE][MODE2_BIT];
  assign blk_count_o = {bank_q[R_CNT_HI], bank_q[R_CNT_LO]};
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk
  import codec_regs_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cs_i,
  input logic                     we_i,
  input logic [1:0]               addr_i,
  input logic [7:0]               rdata_o,
  input logic                     irq_set_i,
  input logic                     irq_o,
  input logic [AW-1:0]            iaddr_i,
  input logic [NUM_REGS-1:0][7:0] bank_i
);
  logic wr_dat;
  assign wr_dat = cs_i && we_i && (addr_i == PORT_DAT);

  p_idx_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && addr_i == PORT_IDX) |=> (rdata_o[7] == 1'b0));

  p_ro_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && iaddr_i == R_ERRINIT) |=> $stable(bank_i[R_ERRINIT]));

  p_rsv_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && (iaddr_i == R_RSV_A || iaddr_i == R_RSV_B || iaddr_i == R_RSV_C))
      |=> ($stable(bank_i[R_RSV_A]) && $stable(bank_i[R_RSV_B]) && $stable(bank_i[R_RSV_C])));

  p_mode_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && iaddr_i == R_MODE) |=> (bank_i[R_MODE][7] && bank_i[R_MODE][5:0] == 6'h0A));

  p_stat_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == PORT_STAT && !irq_set_i) |=> (!irq_o && bank_i[R_ALTSTAT][6:4] == 3'b000));

  p_irq_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> (irq_o && bank_i[R_ALTSTAT][PINT_BIT]));

  p_pio_ign_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == PORT_PIO && !irq_set_i) |=> ($stable(bank_i) && $stable(irq_o)));

  p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && !we_i) |=> $stable(rdata_o));
endmodule

bind codec_regfile codec_regfile_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_set_i (irq_set_i),
  .irq_o     (irq_o),
  .iaddr_i   (iaddr),
  .bank_i    (bank_q)
);

// File: tb/sim_codec_regfile.sv
module sim_codec_regfile;
  localparam int CAL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0, irq_set = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata, fmt, iface;
  logic        irq, mode2;
  logic [15:0] blk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_regfile #(.CAL_READS(CAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_set_i(irq_set), .irq_o(irq),
    .fmt_o(fmt), .iface_o(iface), .mode2_o(mode2), .blk_count_o(blk)
  );

  // bench model
  logic [7:0] m_bank [32];
  logic [7:0] m_idx;
  logic       m_int;
  int         m_cal;

  function automatic logic [7:0] rv(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic int m_ia();
    return m_bank[12][6] ? int'(m_idx[4:0]) : int'(m_idx[3:0]);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) m_bank[i] = rv(i);
    m_idx = 8'h40; m_int = 1'b0; m_cal = 0;
  endtask

  task automatic m_write(input logic [1:0] a, input logic [7:0] d, input bit s);
    int ia;
    case (a)
      2'd0: begin
        if (!m_idx[6] && d[6] && m_bank[9][4:3] != 2'b00) m_cal = CAL;
        m_idx = d & 8'h7F;
      end
      2'd1: begin
        ia = m_ia();
        case (ia)
          8: if (m_idx[6]) m_bank[8] = d;
             else if (m_bank[24][4]) m_bank[8] = {d[7:4], m_bank[8][3:0]};
          9: m_bank[9] = d & 8'hDF;
          11, 22, 27, 29: ;
          12: m_bank[12][6] = d[6];
          24: begin
            if (m_bank[24][4] && !d[4]) m_int = 1'b0;
            m_bank[24] = d;
          end
          default: m_bank[ia] = d;
        endcase
      end
      2'd2: begin m_int = 1'b0; m_bank[24][6:4] = 3'b000; end
      default: ;
    endcase
    if (s) begin m_int = 1'b1; m_bank[24][4] = 1'b1; end
  endtask

  task automatic m_read(input logic [1:0] a, output logic [7:0] e);
    int ia;
    case (a)
      2'd0: e = m_idx;
      2'd1: begin
        ia = m_ia();
        e = m_bank[ia];
        if (ia == 11 && m_cal > 0) begin e[5] = 1'b1; m_cal--; end
      end
      2'd2: e = {7'b0, m_int};
      default: e = 8'h00;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " irq"}, 32'(irq), 32'(m_int));
    chk("R12 fmt", 32'(fmt), 32'(m_bank[8]));
    chk("R12 iface", 32'(iface), 32'(m_bank[9]));
    chk("R12 mode2", 32'(mode2), 32'(m_bank[12][6]));
    chk("R12 blk", 32'(blk), 32'({m_bank[14], m_bank[15]}));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit s = 1'b0);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d; irq_set = s;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; irq_set = 1'b0;
    m_write(a, d, s);
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    m_write(2'd3, 8'h00, 1'b1);
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    m_read(a, e);
    chk(tag, 32'(rdata), 32'(e));
  endtask

  task automatic rd_lit(input logic [1:0] a, input logic [7:0] e, input string tag);
    logic [7:0] dummy;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    m_read(a, dummy);
    chk(tag, 32'(rdata), 32'(e));
  endtask

  task automatic rd_reg(input int r, input logic [7:0] e, input string tag);
    wr(2'd0, 8'(r) | 8'h40);
    rd_lit(2'd1, e, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    rd_lit(2'd0, 8'h40, "R1 index");
    for (int i = 0; i < 16; i++) rd_reg(i, rv(i), "R1 low bank");
    rd_reg(12, 8'h8A, "R1 reg12");
    wr(2'd1, 8'hFF);                        // reg12: only bit 6 may change
    rd_lit(2'd1, 8'hCA, "R6 mode bit only");
    for (int i = 16; i < 32; i++) rd_reg(i, rv(i), "R1 high bank");

    // R3: mask back to 4 bits when mode2 cleared
    rd_reg(12, 8'hCA, "R3 mode2 set");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h5A);                        // 0x1A masked to 10 in compatible mode
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h4A);
    rd_lit(2'd1, 8'h3C, "R3 index masked to 4 bits");

    // R2
    wr(2'd0, 8'hC5);
    rd_lit(2'd0, 8'h45, "R2 index bit7 cleared");

    // R4 format gating
    rd_reg(8, 8'h00, "R4 fmt start");
    wr(2'd1, 8'h5A);
    rd_lit(2'd1, 8'h5A, "R4 full write with MCE");
    wr(2'd0, 8'h08);                        // MCE off
    wr(2'd1, 8'hF1);
    rd_lit(2'd1, 8'h5A, "R4 write dropped");
    wr(2'd0, 8'h18); wr(2'd1, 8'h00);       // compatible mode: idx 0x18 -> reg 8
    rd_lit(2'd1, 8'h5A, "R4 dropped via masked index");
    pulse_irq();                            // sets reg24 bit4
    wr(2'd0, 8'h08);
    wr(2'd1, 8'hF1);
    rd_lit(2'd1, 8'hFA, "R4 partial write upper nibble");
    chk("R9 irq after set", 32'(irq), 32'd1);

    // R8 / R9
    wr(2'd2, 8'h00);
    rd_lit(2'd2, 8'h00, "R8 status cleared");
    chk("R8 irq low", 32'(irq), 32'd0);
    wr(2'd2, 8'h00, 1'b1);
    chk("R9 set wins over clear", 32'(irq), 32'd1);
    rd_lit(2'd2, 8'h01, "R11 status read");
    rd_lit(2'd2, 8'h01, "R11 status read no side effect");

    // R10 via reg24 (needs mode2)
    wr(2'd0, 8'h4C); wr(2'd1, 8'h40);
    wr(2'd0, 8'h58); wr(2'd1, 8'h20);
    chk("R10 irq cleared by reg24 write", 32'(irq), 32'd0);
    rd_lit(2'd1, 8'h20, "R10 reg24 stored");

    // R5
    wr(2'd0, 8'h49); wr(2'd1, 8'hFF);
    rd_lit(2'd1, 8'hDF, "R5 reg9 bit5 zero");
    wr(2'd0, 8'h56); wr(2'd1, 8'h77);
    rd_lit(2'd1, 8'h00, "R5 reserved 22");
    wr(2'd0, 8'h5D); wr(2'd1, 8'h77);
    rd_lit(2'd1, 8'h00, "R5 reserved 29");

    // R7 calibration busy
    wr(2'd0, 8'h09); wr(2'd1, 8'h18);
    wr(2'd0, 8'h4B);                        // rising MCE, arms
    wr(2'd1, 8'hFF);                        // reg11 read-only
    rd_lit(2'd1, 8'h20, "R7 busy read 1");
    rd_lit(2'd1, 8'h20, "R7 busy read 2");
    wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);       // reload
    rd_lit(2'd1, 8'h20, "R7 reload 1");
    rd_lit(2'd1, 8'h20, "R7 reload 2");
    rd_lit(2'd1, 8'h20, "R7 reload 3");
    rd_lit(2'd1, 8'h00, "R7 busy exhausted");
    rd_lit(2'd1, 8'h00, "R5 reg11 unchanged");

    // R11 PIO
    wr(2'd3, 8'hA5);
    rd_lit(2'd3, 8'h00, "R11 pio read");
    chk_outs("R11");

    // R12 read data holds
    rd_lit(2'd0, 8'h4B, "R12 index read");
    held = rdata;
    wr(2'd1, 8'h11);
    chk("R12 rdata holds", 32'(rdata), 32'(held));

    // random traffic
    for (int n = 0; n < 2000; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d  = 8'($urandom);
      case (op)
        0, 1: wr(2'd0, d);
        2, 3: wr(2'd1, d, ($urandom_range(0, 7) == 0));
        4:    rd_chk(2'd1, "R3 random data read");
        5:    rd_chk(2'd0, "R2 random index read");
        6:    wr(2'd2, d, ($urandom_range(0, 3) == 0));
        7:    pulse_irq();
        8:    rd_chk(2'd2, "R8 random status read");
        default: begin wr(2'd3, d); rd_chk(2'd3, "R11 random pio read"); end
      endcase
      if (n % 50 == 0) chk_outs("R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule